// File: doc/BRIEF.md
# Locked-Rotor Protection Timer

This block protects a motor drive stage from a stalled rotor. While the drive is running it watches a strobe that pulses on each rotation edge. It measures the time since the last strobe in ticks of a slow reference oscillator, which arrives as a one-cycle tick input. If 128 reference ticks pass without a rotation strobe, the block latches a fault and forces every gate drive output, high side and low side, to off.

The fault stays latched even if the rotor turns again. Only a stop command (run enable low) or a brake request releases it, and either one also clears the stall counter. Until the fault is latched, the upstream gate commands pass through unchanged. A stall indication output rises as soon as one reference tick has gone by without rotation. It stays high through the whole stall window and while the fault is latched.

The control is a three-state machine. `ST_IDLE` means stopped or braking. `ST_WATCH` means running and timing the stall. `ST_TRIPPED` means the fault is latched. The transitions are:
- IDLE→WATCH when running is commanded without a brake.
- WATCH→IDLE and TRIPPED→IDLE on a stop or a brake.
- WATCH→TRIPPED when the counter wraps past its top value.

Top module: `lrp_lock_guard`

## Requirements
- R1: After reset, `fault` is 0 and `stall` is 0, and `gate_en` equals `gate_cmd`.
- R2: While `fault` is 0, `gate_en` equals `gate_cmd` bit for bit.
- R3: The stall counter advances only on cycles where `osc_tick` is 1. Any number of clock cycles without a tick never trips the block.
- R4: While running with no rotation strobe, `fault` rises in the clock cycle after the 128th counted tick is sampled, and not after the 127th.
- R5: While `fault` is 1, `gate_en` is all zeros, whatever `gate_cmd` holds.
- R6: A `rot_edge` strobe while running and not tripped clears the stall counter to zero, so a fresh full 128 ticks are needed to trip. `stall` is 0 in the following cycle.
- R7: When `rot_edge` and `osc_tick` are both 1 in the same cycle, the strobe wins and the counter becomes zero.
- R8: Once set, `fault` stays 1 while `run_en` is 1 and `brake_req` is 0, even if `rot_edge` strobes arrive.
- R9: `run_en` at 0 clears `fault` and the counter in the next cycle.
- R10: `brake_req` at 1 clears `fault` and the counter in the next cycle, even with `run_en` at 1.
- R11: Ticks that arrive while stopped or braking are not counted. After run resumes, a full 128 ticks are needed to trip.
- R12: `stall` is 1 from the first counted tick without rotation until a clear, and it is 1 whenever `fault` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle pulse from the slow reference oscillator |
| rot_edge | input | 1 | One-cycle strobe on each rotation edge |
| run_en | input | 1 | Run command; 0 means stop |
| brake_req | input | 1 | Brake command |
| gate_cmd | input | GATE_W (6) | Upstream gate drive commands, high and low side |
| gate_en | output | GATE_W (6) | Gate drives after the protection mask |
| fault | output | 1 | Latched locked-rotor fault |
| stall | output | 1 | Stall timing in progress, or fault latched |

## Verification
The trip boundary is the sharpest corner case. The bench stops at 127 ticks, then at 128. An off-by-one counter would trip early or need a 129th tick. The bench strobes rotation and ticks in the same cycle, so a design that lets the tick win would carry a count of one and trip one tick early. It strobes rotation after a trip and expects the fault to stay latched. It sends ticks while stopped and while braking, then checks that a full window is still needed after run resumes. A counter that ran on clock cycles, or kept counting while stopped, would trip too soon.

// File: rtl/lrp_pkg.sv
package lrp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WATCH   = 2'd1,
        ST_TRIPPED = 2'd2
    } lrp_state_t;
endpackage

// File: rtl/lrp_stall_counter.sv
module lrp_stall_counter #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed,
    input  logic             tick,
    input  logic             rot,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    // wrap flags the tick that carries the count past its top value
    assign wrap = armed && tick && !rot && (count == CNT_TOP);

    always_ff @(posedge clk) begin
        if (!rst_n || !armed) begin
            count <= '0;
        end else if (rot) begin
            count <= '0;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/lrp_fsm.sv
module lrp_fsm
    import lrp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic       brake_req,
    input  logic       wrap,
    output lrp_state_t state,
    output logic       armed,
    output logic       tripped
);
    lrp_state_t state_nx;
    logic       go;

    assign go = run_en && !brake_req;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (go) state_nx = ST_WATCH;
            ST_WATCH:   if (!go) state_nx = ST_IDLE;
                        else if (wrap) state_nx = ST_TRIPPED;
            ST_TRIPPED: if (!go) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        armed   = 1'b0;
        tripped = 1'b0;
        unique case (state)
            ST_IDLE:    ;
            ST_WATCH:   armed = 1'b1;
            ST_TRIPPED: tripped = 1'b1;
            default:    ;
        endcase
    end
endmodule

// File: rtl/lrp_gate_mask.sv
module lrp_gate_mask #(
    parameter int GATE_W = 6
) (
    input  logic [GATE_W-1:0] cmd,
    input  logic              kill,
    output logic [GATE_W-1:0] drv
);
    for (genvar i = 0; i < GATE_W; i++) begin : g_bit
        assign drv[i] = cmd[i] & ~kill;
    end
endmodule

// File: rtl/lrp_lock_guard.sv
module lrp_lock_guard #(
    parameter int CNT_W  = 7,
    parameter int GATE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              rot_edge,
    input  logic              run_en,
    input  logic              brake_req,
    input  logic [GATE_W-1:0] gate_cmd,
    output logic [GATE_W-1:0] gate_en,
    output logic              fault,
    output logic              stall
);
    import lrp_pkg::*;

    lrp_state_t       state;
    logic             armed;
    logic             tripped;
    logic             wrap;
    logic [CNT_W-1:0] count;

    lrp_stall_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .armed (armed),
        .tick  (osc_tick),
        .rot   (rot_edge),
        .count (count),
        .wrap  (wrap)
    );

    lrp_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .brake_req (brake_req),
        .wrap      (wrap),
        .state     (state),
        .armed     (armed),
        .tripped   (tripped)
    );

    lrp_gate_mask #(.GATE_W(GATE_W)) u_mask (
        .cmd  (gate_cmd),
        .kill (tripped),
        .drv  (gate_en)
    );

    assign fault = tripped;
    assign stall = tripped || (armed && (count != '0));
endmodule

// File: rtl/lrp_lock_guard_chk.sv
module lrp_lock_guard_chk #(
    parameter int GATE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              osc_tick,
    input logic              rot_edge,
    input logic              run_en,
    input logic              brake_req,
    input logic [GATE_W-1:0] gate_cmd,
    input logic [GATE_W-1:0] gate_en,
    input logic              fault,
    input logic              stall
);
    assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !fault |-> gate_en == gate_cmd);

    assert_trip_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> $past(osc_tick));

    assert_gates_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> gate_en == '0);

    assert_edge_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !brake_req && !fault && rot_edge) |=> !stall);

    assert_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && run_en && !brake_req) |=> fault);

    assert_stop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !fault);

    assert_brake_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        brake_req |=> !fault);

    assert_stall_with_fault_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> stall);
endmodule

bind lrp_lock_guard lrp_lock_guard_chk #(.GATE_W(GATE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_tick  (osc_tick),
    .rot_edge  (rot_edge),
    .run_en    (run_en),
    .brake_req (brake_req),
    .gate_cmd  (gate_cmd),
    .gate_en   (gate_en),
    .fault     (fault),
    .stall     (stall)
);

// File: tb/lrp_lock_guard_test.sv
module lrp_lock_guard_test;
    localparam int GW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          osc_tick = 1'b0;
    logic          rot_edge = 1'b0;
    logic          run_en = 1'b0;
    logic          brake_req = 1'b0;
    logic [GW-1:0] gate_cmd = 6'b101101;
    logic [GW-1:0] gate_en;
    logic          fault;
    logic          stall;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lrp_lock_guard uut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .rot_edge(rot_edge),
        .run_en(run_en), .brake_req(brake_req), .gate_cmd(gate_cmd),
        .gate_en(gate_en), .fault(fault), .stall(stall)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            osc_tick = 1'b1;
            @(negedge clk);
            osc_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic strobe(input bit with_tick);
        rot_edge = 1'b1;
        osc_tick = with_tick;
        @(negedge clk);
        rot_edge = 1'b0;
        osc_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic restart();
        run_en = 1'b0;
        brake_req = 1'b0;
        @(negedge clk);
        run_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 fault", fault, 0);
        chk("R1 stall", stall, 0);
        chk("R1 gate_en", gate_en, gate_cmd);
    endtask

    task automatic t_passthrough();
        restart();
        gate_cmd = 6'b010011;
        #1 chk("R2 gate pass a", gate_en, 6'b010011);
        gate_cmd = 6'b111111;
        #1 chk("R2 gate pass b", gate_en, 6'b111111);
    endtask

    task automatic t_no_tick();
        restart();
        repeat (400) @(negedge clk);
        chk("R3 no trip without ticks", fault, 0);
        chk("R3 no stall without ticks", stall, 0);
        ticks(1);
        chk("R12 stall after first tick", stall, 1);
    endtask

    task automatic t_trip();
        restart();
        gate_cmd = 6'b110110;
        ticks(127);
        chk("R4 no trip at 127", fault, 0);
        chk("R12 stall held", stall, 1);
        osc_tick = 1'b1;
        @(negedge clk);
        osc_tick = 1'b0;
        chk("R4 trip after 128", fault, 1);
        chk("R5 gates off", gate_en, 0);
        gate_cmd = 6'b111111;
        #1 chk("R5 gates off any cmd", gate_en, 0);
        chk("R12 stall while fault", stall, 1);
    endtask

    task automatic t_edge_clear();
        restart();
        ticks(100);
        strobe(1'b0);
        chk("R6 stall cleared by edge", stall, 0);
        ticks(127);
        chk("R6 no trip after fresh 127", fault, 0);
        ticks(1);
        chk("R6 trip after fresh 128", fault, 1);
    endtask

    task automatic t_simul();
        restart();
        ticks(127);
        strobe(1'b1);
        chk("R7 edge beats tick", fault, 0);
        chk("R7 count zero", stall, 0);
        ticks(127);
        chk("R7 no trip at 127", fault, 0);
        ticks(1);
        chk("R7 trip at 128", fault, 1);
    endtask

    task automatic t_latch();
        restart();
        ticks(128);
        chk("R8 tripped", fault, 1);
        strobe(1'b0);
        strobe(1'b1);
        ticks(5);
        chk("R8 still latched", fault, 1);
        chk("R8 gates still off", gate_en, 0);
    endtask

    task automatic t_run_clear();
        run_en = 1'b0;
        @(negedge clk);
        chk("R9 fault cleared by stop", fault, 0);
        chk("R9 gates restored", gate_en, gate_cmd);
        run_en = 1'b1;
        @(negedge clk);
        ticks(127);
        chk("R9 counter cleared", fault, 0);
    endtask

    task automatic t_brake_clear();
        restart();
        ticks(128);
        chk("R10 tripped", fault, 1);
        brake_req = 1'b1;
        @(negedge clk);
        chk("R10 brake clears fault", fault, 0);
        ticks(200);
        chk("R11 no count while braking", fault, 0);
        chk("R11 no stall while braking", stall, 0);
        brake_req = 1'b0;
        @(negedge clk);
        ticks(127);
        chk("R10 counter cleared by brake", fault, 0);
        ticks(1);
        chk("R10 trip after full window", fault, 1);
    endtask

    task automatic t_stopped_ticks();
        run_en = 1'b0;
        @(negedge clk);
        ticks(200);
        chk("R11 no fault while stopped", fault, 0);
        run_en = 1'b1;
        @(negedge clk);
        ticks(127);
        chk("R11 full window needed", fault, 0);
        ticks(1);
        chk("R11 trip after 128", fault, 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_passthrough();
        t_no_tick();
        t_trip();
        t_edge_clear();
        t_simul();
        t_latch();
        t_run_clear();
        t_brake_clear();
        t_stopped_ticks();
        finish_run();
    end

    initial begin
        #(8 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule